// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. It takes one word-sized read or write at a time through a valid/ready handshake. For each one it plays out a cycle on the RAM pins: chip select, output enable, write enable and two active-low lane selects. It also drives the bidirectional data bus.

The length of every phase is worked out at elaboration from the clock period and the RAM's nanosecond minimums. The same source therefore meets the RAM's timing at any clock rate. Each minimum is rounded up to whole clocks, with at least one clock per phase. Writes use a short bus turnaround before the controller drives data, then a write-enable pulse, then a recovery clock. Reads hold the select signals for the full access time, capture the bus at the final edge, and return the data with a single-cycle valid pulse and a lane mask.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever no cycle is in progress, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are all high, req_ready is high, and the controller does not drive mem_dq.
- R2: req_ready is low from the clock after a request is accepted until that cycle has finished, and only one cycle is in progress at any time.
- R3: A read holds mem_ce_n and mem_oe_n low, and keeps mem_addr stable, for ceil(55 ns / clock period) clocks. It samples mem_dq at the edge that ends that window and pulses rsp_valid high for exactly one clock, starting at that same edge.
- R4: For read data, rsp_lanes bit 0 marks bits 7:0 as valid and bit 1 marks bits 15:8. A lane that was not requested reads as zero in rsp_rdata.
- R5: During a write, mem_oe_n stays high. mem_we_n is low for ceil(50 ns / clock period) clocks, and mem_ce_n and the selected lane strobes are low for the whole time mem_we_n is low.
- R6: req_be bit 0 drives mem_lb_n and gates data bits 7:0; bit 1 drives mem_ub_n and gates bits 15:8. A write changes only the selected bytes in the RAM.
- R7: The controller starts driving mem_dq only after mem_oe_n has been high for at least ceil(20 ns / clock period) clocks, and it never drives while mem_oe_n is low.
- R8: The controller keeps its data drivers on through the clock in which mem_we_n rises, and releases them when the write cycle ends.
- R9: A request with req_be equal to zero runs a full cycle with both lane strobes high, so the RAM contents do not change.
- R10: Each cycle keeps mem_ce_n low for at least ceil(55 ns / clock period) clocks, and the address changes only between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 16 | Read data, zero in lanes that were not requested |
| rsp_lanes | output | 2 | Lanes valid in rsp_rdata |
| mem_addr | output | 18 | RAM address |
| mem_dq | inout | 16 | RAM data bus |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | RAM lower lane select, active low |
| mem_ub_n | output | 1 | RAM upper lane select, active low |

## Verification
The clock that ends a read also delivers its response. In that same clock the controller returns to idle and can accept the next request, so a read response and a new handshake fall in the same cycle. The bench provokes this by holding req_valid high across back-to-back read/write/read sequences with no idle gap. It judges the result in two ways. The scoreboard checks that the response pops in order with the right data. A RAM model in the bench corrupts any write whose pulse is too short and returns a poison value for any read sampled too early, so a following write that started too soon, or one whose bus turnaround was lost, shows up in a later read.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_PULSE,
        PH_REC
    } phase_e;

    // whole clocks covering a nanosecond minimum, never less than one
    function automatic int cycles_for(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 55,
    parameter int T_AA_NS  = 55,
    parameter int T_BA_NS  = 55,
    parameter int T_OE_NS  = 35,
    parameter int T_WC_NS  = 55,
    parameter int T_WP_NS  = 40,
    parameter int T_AW_NS  = 50,
    parameter int T_CW_NS  = 50,
    parameter int T_BW_NS  = 50,
    parameter int T_DW_NS  = 25,
    parameter int T_HZ_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    output logic              cap_now,
    output logic              rsp_valid,
    output logic [LANES-1:0]  rsp_lanes,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdat_o,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [LANES-1:0]  bs_n,
    output logic              drive
);

    localparam int R_CNT     = max_i(max_i(cycles_for(T_AA_NS, CLK_NS), cycles_for(T_BA_NS, CLK_NS)),
                                     max_i(cycles_for(T_OE_NS, CLK_NS), cycles_for(T_RC_NS, CLK_NS)));
    localparam int TURN_CNT  = cycles_for(T_HZ_NS, CLK_NS);
    localparam int PULSE_NS  = max_i(max_i(T_WP_NS, T_AW_NS), max_i(max_i(T_CW_NS, T_BW_NS), T_DW_NS));
    localparam int PULSE_CNT = cycles_for(PULSE_NS, CLK_NS);
    localparam int REC_CNT   = max_i(1, cycles_for(T_WC_NS, CLK_NS) - PULSE_CNT - TURN_CNT);
    localparam int MAX_CNT   = max_i(max_i(R_CNT, TURN_CNT), max_i(PULSE_CNT, REC_CNT));
    localparam int CNT_W     = $clog2(MAX_CNT + 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  bs_n;
        logic              drive;
        logic              rvalid;
        logic [LANES-1:0]  lanes;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        ph:     PH_IDLE,
        cnt:    '0,
        addr:   '0,
        wdat:   '0,
        ce_n:   1'b1,
        oe_n:   1'b1,
        we_n:   1'b1,
        bs_n:   '1,
        drive:  1'b0,
        rvalid: 1'b0,
        lanes:  '0
    };

    seq_t seq_d, seq_q;
    logic cap_d;

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        cap_d        = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.lanes = req_be;
                    seq_d.bs_n  = ~req_be;
                    seq_d.ce_n  = 1'b0;
                    if (req_write) begin
                        seq_d.ph   = PH_TURN;
                        seq_d.wdat = req_wdata;
                        seq_d.cnt  = CNT_W'(TURN_CNT - 1);
                    end else begin
                        seq_d.ph   = PH_READ;
                        seq_d.oe_n = 1'b0;
                        seq_d.cnt  = CNT_W'(R_CNT - 1);
                    end
                end
            end
            PH_READ: begin
                if (seq_q.cnt == '0) begin
                    cap_d        = 1'b1;
                    seq_d.rvalid = 1'b1;
                    seq_d.ph     = PH_IDLE;
                    seq_d.ce_n   = 1'b1;
                    seq_d.oe_n   = 1'b1;
                    seq_d.bs_n   = '1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph    = PH_PULSE;
                    seq_d.we_n  = 1'b0;
                    seq_d.drive = 1'b1;
                    seq_d.cnt   = CNT_W'(PULSE_CNT - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_PULSE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph   = PH_REC;
                    seq_d.we_n = 1'b1;
                    seq_d.cnt  = CNT_W'(REC_CNT - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_REC: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph    = PH_IDLE;
                    seq_d.ce_n  = 1'b1;
                    seq_d.bs_n  = '1;
                    seq_d.drive = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign req_ready = (seq_q.ph == PH_IDLE);
    assign cap_now   = cap_d;
    assign rsp_valid = seq_q.rvalid;
    assign rsp_lanes = seq_q.lanes;
    assign addr_o    = seq_q.addr;
    assign wdat_o    = seq_q.wdat;
    assign ce_n      = seq_q.ce_n;
    assign oe_n      = seq_q.oe_n;
    assign we_n      = seq_q.we_n;
    assign bs_n      = seq_q.bs_n;
    assign drive     = seq_q.drive;

endmodule

// File: rtl/asram_lane.sv
module asram_lane
    import asram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              sel,
    input  logic [LANE_W-1:0] pad_i,
    output logic [LANE_W-1:0] rbyte_o
);

    logic [LANE_W-1:0] rbyte_d, rbyte_q;

    always_comb begin
        rbyte_d = rbyte_q;
        if (cap) rbyte_d = sel ? pad_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rbyte_q <= '0;
        else        rbyte_q <= rbyte_d;
    end

    assign rbyte_o = rbyte_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_BA_NS = 55,
    parameter int T_OE_NS = 35,
    parameter int T_WC_NS = 55,
    parameter int T_WP_NS = 40,
    parameter int T_AW_NS = 50,
    parameter int T_CW_NS = 50,
    parameter int T_BW_NS = 50,
    parameter int T_DW_NS = 25,
    parameter int T_HZ_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [1:0]        rsp_lanes,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [15:0]       mem_dq,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n
);

    logic              cap_now;
    logic              dq_drive;
    logic [LANES-1:0]  bs_n;
    logic [DATA_W-1:0] wdat;

    asram_seq #(
        .ADDR_W (ADDR_W),  .CLK_NS (CLK_NS),
        .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_BA_NS(T_BA_NS), .T_OE_NS(T_OE_NS),
        .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS), .T_AW_NS(T_AW_NS), .T_CW_NS(T_CW_NS),
        .T_BW_NS(T_BW_NS), .T_DW_NS(T_DW_NS), .T_HZ_NS(T_HZ_NS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_be   (req_be),
        .req_ready(req_ready),
        .cap_now  (cap_now),
        .rsp_valid(rsp_valid),
        .rsp_lanes(rsp_lanes),
        .addr_o   (mem_addr),
        .wdat_o   (wdat),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .bs_n     (bs_n),
        .drive    (dq_drive)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_dq[g*LANE_W +: LANE_W] = dq_drive ? wdat[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};

        asram_lane lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap    (cap_now),
            .sel    (rsp_lanes[g]),
            .pad_i  (mem_dq[g*LANE_W +: LANE_W]),
            .rbyte_o(rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    assign mem_lb_n = bs_n[0];
    assign mem_ub_n = bs_n[1];

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 55,
    parameter int T_WP_NS = 40,
    parameter int T_AW_NS = 50,
    parameter int T_HZ_NS = 20
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic lb_n,
    input logic ub_n,
    input logic drive
);

    localparam int RD_MIN   = cycles_for(T_RC_NS, CLK_NS);
    localparam int WE_MIN   = cycles_for(max_i(T_WP_NS, T_AW_NS), CLK_NS);
    localparam int TURN_MIN = cycles_for(T_HZ_NS, CLK_NS);
    localparam int SAT      = 4096;

    int oe_lo_cnt, oe_hi_cnt, we_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_lo_cnt <= 0;
            oe_hi_cnt <= 0;
            we_lo_cnt <= 0;
        end else begin
            oe_lo_cnt <= !oe_n ? ((oe_lo_cnt < SAT) ? oe_lo_cnt + 1 : oe_lo_cnt) : 0;
            oe_hi_cnt <=  oe_n ? ((oe_hi_cnt < SAT) ? oe_hi_cnt + 1 : oe_hi_cnt) : 0;
            we_lo_cnt <= !we_n ? ((we_lo_cnt < SAT) ? we_lo_cnt + 1 : we_lo_cnt) : 0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && oe_n && we_n && lb_n && ub_n && !drive));

    // R5
    write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n));

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_lo_cnt >= WE_MIN));

    // R3
    read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_lo_cnt >= RD_MIN));

    // R3
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(oe_n) == 1'b0 && !$past(rsp_valid)));

    // R7
    drive_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> oe_n);

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> (oe_hi_cnt >= TURN_MIN));

    // R8
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> drive);

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .CLK_NS (CLK_NS),
    .T_RC_NS(T_RC_NS),
    .T_WP_NS(T_WP_NS),
    .T_AW_NS(T_AW_NS),
    .T_HZ_NS(T_HZ_NS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .lb_n     (mem_lb_n),
    .ub_n     (mem_ub_n),
    .drive    (dq_drive)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RD_NEED    = (55 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int TURN_NEED  = (20 + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [1:0]  rsp_lanes;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_lanes(rsp_lanes),
        .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- RAM model with timing-sensitive behaviour ----------------
    logic [15:0] ram [logic [17:0]];
    logic [15:0] rd_word = 16'h0;
    int          rd_cnt = 0;
    logic        rd_en;
    int          wcnt [2];
    logic [7:0]  pend [2];
    logic        wact_q [2];

    function automatic logic [15:0] ram_get(input logic [17:0] a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction

    assign rd_en = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_en && !mem_lb_n) ? rd_word[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_en && !mem_ub_n) ? rd_word[15:8] : 8'hzz;

    initial begin
        for (int i = 0; i < 2; i++) begin
            wcnt[i] = 0; pend[i] = 8'h0; wact_q[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        logic [1:0]  sel_n;
        logic [15:0] w;
        sel_n = {mem_ub_n, mem_lb_n};
        rd_cnt = rd_en ? rd_cnt + 1 : 0;
        if (rd_en) rd_word = (rd_cnt * CLK_PERIOD >= 55) ? ram_get(mem_addr) : 16'hBAD0;
        for (int i = 0; i < 2; i++) begin
            if (!mem_ce_n && !mem_we_n && !sel_n[i]) begin
                wcnt[i] = wcnt[i] + 1;
                pend[i] = mem_dq[i*8 +: 8];
                wact_q[i] = 1'b1;
            end else begin
                if (wact_q[i]) begin
                    w = ram_get(mem_addr);
                    w[i*8 +: 8] = (wcnt[i] * CLK_PERIOD >= 50) ? pend[i] : 8'hEE;
                    ram[mem_addr] = w;
                end
                wcnt[i] = 0;
                wact_q[i] = 1'b0;
            end
        end
    end

    // ---------------- pin-level timing observers ----------------
    int  contention = 0, short_ce = 0, short_turn = 0, addr_moves = 0;
    int  ce_run = 0, oe_hi_run = 0;
    logic we_prev = 1'b1, ce_prev = 1'b1;
    logic [17:0] addr_prev = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && !mem_we_n) contention++;
            if (!mem_ce_n && !ce_prev && mem_addr != addr_prev) addr_moves++;
            if (!mem_ce_n) ce_run++;
            else begin
                if (!ce_prev && ce_run < RD_NEED) short_ce++;
                ce_run = 0;
            end
            if (!mem_we_n && we_prev && oe_hi_run < TURN_NEED) short_turn++;
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
        end
        we_prev = mem_we_n;
        ce_prev = mem_ce_n;
        addr_prev = mem_addr;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] data;
        logic [1:0]  lanes;
        string       tag;
    } exp_t;
    exp_t        sb [$];
    logic [15:0] shadow [logic [17:0]];

    function automatic logic [15:0] sh_get(input logic [17:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected response", {16'h0, rsp_rdata}, 32'h0);
            end else begin
                e = sb.pop_front();
                check(rsp_rdata == e.data, {e.tag, " data"}, {16'h0, rsp_rdata}, {16'h0, e.data});
                check(rsp_lanes == e.lanes, "R4 lanes", {30'h0, rsp_lanes}, {30'h0, e.lanes});
            end
        end
    end

    // assumes the caller is at a negative edge; returns at the negative edge after acceptance
    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b0, "R2 busy after accept", {31'h0, req_ready}, 32'h0);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] w;
        w = sh_get(a);
        if (be[0]) w[7:0]  = d[7:0];
        if (be[1]) w[15:8] = d[15:8];
        shadow[a] = w;
        issue(1'b1, a, d, be);
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] be, input string tag);
        exp_t e;
        e.data  = sh_get(a) & {{8{be[1]}}, {8{be[0]}}};
        e.lanes = be;
        e.tag   = tag;
        sb.push_back(e);
        issue(1'b0, a, 16'h0, be);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1 strobes after reset",
              {27'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1f);
        check(req_ready == 1'b1, "R1 ready after reset", {31'h0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R1 no response after reset", {31'h0, rsp_valid}, 32'h0);

        // R5 full-word write, R3 full-word read
        do_write(18'h00010, 16'hA5C3, 2'b11);
        go_idle();
        do_read(18'h00010, 2'b11, "R3 full read");
        go_idle();
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1 strobes between cycles",
              {27'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1f);

        // R6 lower-lane write leaves upper byte
        do_write(18'h00010, 16'h1177, 2'b01);
        go_idle();
        do_read(18'h00010, 2'b11, "R6 lower-only write");
        // R6 upper-lane write
        do_write(18'h3FFFF, 16'hBE00, 2'b10);
        do_read(18'h3FFFF, 2'b11, "R6 upper-only write");
        // R4 single-lane reads
        do_read(18'h00010, 2'b01, "R4 lower-lane read");
        do_read(18'h00010, 2'b10, "R4 upper-lane read");
        go_idle();

        // R9 empty mask write changes nothing
        do_write(18'h00010, 16'hFFFF, 2'b00);
        go_idle();
        do_read(18'h00010, 2'b11, "R9 empty mask");
        do_read(18'h00010, 2'b00, "R9 empty read mask");
        go_idle();

        // back-to-back: response and next acceptance in one clock, R7 turnaround after a read
        for (int k = 0; k < 6; k++) begin
            do_write(18'h00100 + 18'(k), 16'h3000 + 16'(k * 16'h0111), 2'b11);
            do_read(18'h00100 + 18'(k), 2'b11, "R7 read then write");
        end
        do_read(18'h00055, 2'b11, "R3 unwritten word");
        for (int k = 0; k < 6; k++) begin
            do_read(18'h00100 + 18'(k), 2'b11, "R8 data held to end of write");
        end
        go_idle();

        repeat (50) begin
            if (sb.size() == 0) break;
            @(negedge clk);
        end
        check(sb.size() == 0, "R3 responses outstanding", sb.size(), 32'h0);
        check(contention == 0, "R5 output enable during write", contention, 32'h0);
        check(short_ce == 0, "R10 chip-select window short", short_ce, 32'h0);
        check(addr_moves == 0, "R10 address moved mid-cycle", addr_moves, 32'h0);
        check(short_turn == 0, "R7 turnaround short", short_turn, 32'h0);
        check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111 && req_ready,
              "R1 idle at end", {27'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1f);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog expired actual=hung expected=complete");
            finish_run();
        end
    end

endmodule